// File: doc/BRIEF.md
# Stack Push-Pop Sequencer

This block runs the stack traffic of a small 8-bit processor. A command goes in, and the block issues one byte-wide memory cycle after another until the command is done. The commands are: subroutine call and return, maskable interrupt entry, software break, return from interrupt, and a single-byte push or pop. The block owns the 8-bit stack pointer. Each stack address is that pointer with a one-bit page select above it, so the stack sits in page 0x00 or page 0x01. The page bit is captured when a command is accepted.

Interrupt and break entry save three bytes and then read a two-byte vector from a fixed address. The vector address depends on the interrupt source, or is a fixed break address for a break. The block returns the program counter to continue from and the status byte to load. A pop also returns the byte it read. Commands arrive over a valid/ready pair. `cmd_ready` stays low from acceptance until completion, so the issuer is held off. The memory side is also valid/ready: the block holds address, direction and write data steady until `mem_ready` is seen. Read data is taken in the cycle of that handshake.

Status bits used: interrupt-disable is bit 2, break is bit 4. Command codes on `cmd_op`: 1 call, 2 return, 3 interrupt, 4 return-from-interrupt, 5 break, 6 push, 7 pop. Code 0 is accepted and does nothing.

Top module: `stk_seq`

## Requirements
- R1: Every stack cycle addresses {7'b0, page, pointer}, where page is `page_sel` captured at acceptance. Writes use the pointer. Reads use pointer+1. Reset leaves the pointer at 0xFF.
- R2: Call (code 1) writes the high byte of `cmd_pc`-1 at the stack address, decrements, writes the low byte of `cmd_pc`-1, and decrements again.
- R3: Return (code 2) increments and reads the low byte, then increments and reads the high byte. It reports `res_pc` = {high, low} + 1.
- R4: Interrupt (code 3) writes `cmd_pc` high, `cmd_pc` low, then the status with bit 4 cleared, decrementing after each write. It then reads the vector low byte at 0xFFFC - 2*`cmd_src` and the high byte one address above. `res_pc` is the vector. `res_ps` is `cmd_ps` with bit 2 set and bit 4 clear.
- R5: Break (code 5) runs the same sequence with bit 4 set in the saved status and the vector at 0xFFDC. It ignores both `cmd_irq_en` and bit 2.
- R6: Interrupt code 3 with `cmd_irq_en` low, or with bit 2 of `cmd_ps` set, is accepted and ignored: no memory cycle, no result, pointer unchanged.
- R7: Return-from-interrupt (code 4) increments before each read, reading status, then PC low, then PC high. `res_pc` is exactly the popped address. `res_ps` is the popped status with bit 4 cleared.
- R8: Push (code 6) writes `cmd_data` and then decrements. Pop (code 7) increments, reads, and reports the byte on `res_data`.
- R9: The pointer wraps modulo 256 inside the selected page, with no overflow indication.
- R10: While a memory cycle waits for `mem_ready`, its address, direction and write data do not change. `cmd_ready` stays low while a command is in progress.
- R11: `res_valid` pulses for one cycle, the cycle after the last memory handshake of a command. `cmd_ready` is high in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| page_sel | input | 1 | Stack page select, captured at command acceptance |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle and able to accept |
| cmd_op | input | 3 | Command code |
| cmd_pc | input | 16 | Address of the next instruction |
| cmd_ps | input | 8 | Current status byte |
| cmd_data | input | 8 | Byte to push |
| cmd_irq_en | input | 1 | Enable bit of the requesting interrupt source |
| cmd_src | input | 2 | Interrupt source index |
| mem_valid | output | 1 | Memory cycle requested |
| mem_ready | input | 1 | Memory accepts the cycle this clock |
| mem_we | output | 1 | 1 for a write cycle, 0 for a read cycle |
| mem_addr | output | 16 | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, valid at the handshake |
| sp | output | 8 | Stack pointer |
| res_valid | output | 1 | Completion pulse |
| res_pc | output | 16 | Restored or vector program counter |
| res_ps | output | 8 | Status to load |
| res_data | output | 8 | Popped byte |

## Verification
Calls, returns, pushes and pops are paired with arbitrary PC and data values. A return that comes back to the caller's address separates the minus-one store from the plus-one restore. Interrupt and break entries followed by a return-from-interrupt show whether the break bit is forced in the stored copy and cleared in the restored one, and whether distinct sources select distinct vectors. The same pairs are run with the pointer at 0x00 and 0xFF and in page 1, which exposes wrap or page errors. A pseudo-random `mem_ready` pattern checks that stalled cycles hold still and that results stay aligned with the final handshake. Interrupts with the enable low or the disable flag set must produce no traffic at all.

// File: rtl/stk_pkg.sv
package stk_pkg;

  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_CALL = 3'd1,
    OP_RET  = 3'd2,
    OP_IRQ  = 3'd3,
    OP_RTI  = 3'd4,
    OP_BRK  = 3'd5,
    OP_PUSH = 3'd6,
    OP_POP  = 3'd7
  } op_e;

  typedef enum logic [3:0] {
    ST_WPCH, ST_WPCL, ST_WPS, ST_WDAT,
    ST_RPCL, ST_RPCH, ST_RPS, ST_RDAT,
    ST_RVLO, ST_RVHI
  } step_e;

  localparam int PS_IDIS  = 2;
  localparam int PS_BREAK = 4;

  function automatic logic step_is_write(input step_e k);
    return (k == ST_WPCH) || (k == ST_WPCL) || (k == ST_WPS) || (k == ST_WDAT);
  endfunction

  function automatic logic step_is_vector(input step_e k);
    return (k == ST_RVLO) || (k == ST_RVHI);
  endfunction

endpackage

// File: rtl/stk_step.sv
module stk_step
  import stk_pkg::*;
(
  input  op_e        op,
  input  logic [2:0] idx,
  output step_e      kind,
  output logic       last
);
  always_comb begin
    kind = ST_RDAT;
    last = 1'b1;
    unique case (op)
      OP_CALL: begin
        kind = (idx == 3'd0) ? ST_WPCH : ST_WPCL;
        last = (idx == 3'd1);
      end
      OP_RET: begin
        kind = (idx == 3'd0) ? ST_RPCL : ST_RPCH;
        last = (idx == 3'd1);
      end
      OP_IRQ, OP_BRK: begin
        case (idx)
          3'd0:    kind = ST_WPCH;
          3'd1:    kind = ST_WPCL;
          3'd2:    kind = ST_WPS;
          3'd3:    kind = ST_RVLO;
          default: kind = ST_RVHI;
        endcase
        last = (idx == 3'd4);
      end
      OP_RTI: begin
        case (idx)
          3'd0:    kind = ST_RPS;
          3'd1:    kind = ST_RPCL;
          default: kind = ST_RPCH;
        endcase
        last = (idx == 3'd2);
      end
      OP_PUSH: begin
        kind = ST_WDAT;
        last = 1'b1;
      end
      default: begin
        kind = ST_RDAT;
        last = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/stk_ptr.sv
module stk_ptr #(
  parameter logic [7:0] SP_RESET = 8'hFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        page,
  input  logic        dec,
  input  logic        inc,
  output logic [7:0]  sp,
  output logic [15:0] wr_addr,
  output logic [15:0] rd_addr
);
  logic [7:0] sp_q;

  always_ff @(posedge clk) begin
    if (!rst_n)   sp_q <= SP_RESET;
    else if (dec) sp_q <= sp_q - 8'd1;
    else if (inc) sp_q <= sp_q + 8'd1;
  end

  assign sp      = sp_q;
  assign wr_addr = {7'd0, page, sp_q};
  assign rd_addr = {7'd0, page, sp_q + 8'd1};
endmodule

// File: rtl/stk_vec.sv
module stk_vec #(
  parameter int          NSRC    = 4,
  parameter int          SRC_W   = 2,
  parameter logic [15:0] VEC_TOP = 16'hFFFC,
  parameter logic [15:0] BRK_VEC = 16'hFFDC
) (
  input  logic             is_brk,
  input  logic [SRC_W-1:0] src,
  output logic [15:0]      vec
);
  logic [15:0] tab [NSRC];

  for (genvar g = 0; g < NSRC; g++) begin : g_vec
    assign tab[g] = VEC_TOP - 16'(2 * g);
  end

  assign vec = is_brk ? BRK_VEC : tab[src];
endmodule

// File: rtl/stk_seq.sv
module stk_seq
  import stk_pkg::*;
#(
  parameter int          NSRC     = 4,
  parameter logic [7:0]  SP_RESET = 8'hFF,
  parameter logic [15:0] VEC_TOP  = 16'hFFFC,
  parameter logic [15:0] BRK_VEC  = 16'hFFDC,
  localparam int         SRC_W    = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             page_sel,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [2:0]       cmd_op,
  input  logic [15:0]      cmd_pc,
  input  logic [7:0]       cmd_ps,
  input  logic [7:0]       cmd_data,
  input  logic             cmd_irq_en,
  input  logic [SRC_W-1:0] cmd_src,
  output logic             mem_valid,
  input  logic             mem_ready,
  output logic             mem_we,
  output logic [15:0]      mem_addr,
  output logic [7:0]       mem_wdata,
  input  logic [7:0]       mem_rdata,
  output logic [7:0]       sp,
  output logic             res_valid,
  output logic [15:0]      res_pc,
  output logic [7:0]       res_ps,
  output logic [7:0]       res_data
);
  localparam logic [7:0] IDIS_M  = 8'(1 << PS_IDIS);
  localparam logic [7:0] BREAK_M = 8'(1 << PS_BREAK);

  op_e         op_in;
  logic        busy_q;
  op_e         op_q;
  logic [2:0]  idx_q;
  logic [15:0] pc_q;
  logic [7:0]  ps_push_q;
  logic [7:0]  ps_in_q;
  logic [7:0]  data_q;
  logic [15:0] vec_q;
  logic        page_q;
  logic [7:0]  lo_q;
  logic [7:0]  pops_q;

  logic        accept;
  logic        take;
  logic        hs;
  step_e       kind;
  logic        last;
  logic        kind_wr;
  logic        kind_vec;
  logic [15:0] vec_in;
  logic [15:0] st_wr_addr;
  logic [15:0] st_rd_addr;

  assign op_in  = op_e'(cmd_op);
  assign accept = cmd_valid && !busy_q;
  assign take   = accept && (op_in != OP_NOP) &&
                  !((op_in == OP_IRQ) && (!cmd_irq_en || cmd_ps[PS_IDIS]));
  assign hs     = busy_q && mem_ready;

  stk_step u_step (
    .op   (op_q),
    .idx  (idx_q),
    .kind (kind),
    .last (last)
  );

  assign kind_wr  = step_is_write(kind);
  assign kind_vec = step_is_vector(kind);

  stk_ptr #(.SP_RESET(SP_RESET)) u_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .page    (page_q),
    .dec     (hs && kind_wr),
    .inc     (hs && !kind_wr && !kind_vec),
    .sp      (sp),
    .wr_addr (st_wr_addr),
    .rd_addr (st_rd_addr)
  );

  stk_vec #(
    .NSRC    (NSRC),
    .SRC_W   (SRC_W),
    .VEC_TOP (VEC_TOP),
    .BRK_VEC (BRK_VEC)
  ) u_vec (
    .is_brk (op_in == OP_BRK),
    .src    (cmd_src),
    .vec    (vec_in)
  );

  // memory request is a pure function of the held step state
  assign cmd_ready = !busy_q;
  assign mem_valid = busy_q;
  assign mem_we    = busy_q && kind_wr;

  always_comb begin
    if (kind == ST_RVLO)      mem_addr = vec_q;
    else if (kind == ST_RVHI) mem_addr = vec_q + 16'd1;
    else if (kind_wr)         mem_addr = st_wr_addr;
    else                      mem_addr = st_rd_addr;
  end

  always_comb begin
    unique case (kind)
      ST_WPCH: mem_wdata = pc_q[15:8];
      ST_WPCL: mem_wdata = pc_q[7:0];
      ST_WPS:  mem_wdata = ps_push_q;
      ST_WDAT: mem_wdata = data_q;
      default: mem_wdata = 8'd0;
    endcase
  end

  // command capture and step advance
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      op_q      <= OP_NOP;
      idx_q     <= 3'd0;
      pc_q      <= 16'd0;
      ps_push_q <= 8'd0;
      ps_in_q   <= 8'd0;
      data_q    <= 8'd0;
      vec_q     <= 16'd0;
      page_q    <= 1'b0;
    end else if (take) begin
      busy_q    <= 1'b1;
      op_q      <= op_in;
      idx_q     <= 3'd0;
      pc_q      <= (op_in == OP_CALL) ? cmd_pc - 16'd1 : cmd_pc;
      ps_push_q <= (op_in == OP_BRK) ? (cmd_ps | BREAK_M) : (cmd_ps & ~BREAK_M);
      ps_in_q   <= cmd_ps;
      data_q    <= cmd_data;
      vec_q     <= vec_in;
      page_q    <= page_sel;
    end else if (hs) begin
      if (last) busy_q <= 1'b0;
      else      idx_q  <= idx_q + 3'd1;
    end
  end

  // read capture and result formation
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q      <= 8'd0;
      pops_q    <= 8'd0;
      res_valid <= 1'b0;
      res_pc    <= 16'd0;
      res_ps    <= 8'd0;
      res_data  <= 8'd0;
    end else begin
      res_valid <= hs && last;
      if (hs) begin
        unique case (kind)
          ST_RPCL, ST_RVLO: lo_q   <= mem_rdata;
          ST_RPS:           pops_q <= mem_rdata;
          ST_RPCH: begin
            if (op_q == OP_RTI) begin
              res_pc <= {mem_rdata, lo_q};
              res_ps <= pops_q & ~BREAK_M;
            end else begin
              res_pc <= {mem_rdata, lo_q} + 16'd1;
            end
          end
          ST_RVHI: begin
            res_pc <= {mem_rdata, lo_q};
            res_ps <= (ps_in_q | IDIS_M) & ~BREAK_M;
          end
          ST_RDAT: res_data <= mem_rdata;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/stk_seq_chk.sv
module stk_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_ready,
  input logic        mem_valid,
  input logic        mem_ready,
  input logic        mem_we,
  input logic [15:0] mem_addr,
  input logic [7:0]  mem_wdata,
  input logic [7:0]  sp,
  input logic        res_valid
);
  assert_write_at_pointer_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_we |-> (mem_addr[7:0] == sp) && (mem_addr[15:9] == 7'd0));

  assert_pointer_down_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_ready && mem_we |=> sp == $past(sp) - 8'd1);

  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_we)
                                && $stable(mem_wdata));

  assert_busy_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> !cmd_ready);

  assert_single_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  assert_ready_at_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> cmd_ready && !mem_valid);
endmodule

bind stk_seq stk_seq_chk u_stk_seq_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_ready (cmd_ready),
  .mem_valid (mem_valid),
  .mem_ready (mem_ready),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .sp        (sp),
  .res_valid (res_valid)
);

// File: tb/stk_seq_bench.sv
`timescale 1ns/1ps
module stk_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        page_sel = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [2:0]  cmd_op = 3'd0;
  logic [15:0] cmd_pc = 16'd0;
  logic [7:0]  cmd_ps = 8'd0;
  logic [7:0]  cmd_data = 8'd0;
  logic        cmd_irq_en = 1'b0;
  logic [1:0]  cmd_src = 2'd0;
  logic        mem_valid;
  logic        mem_ready = 1'b1;
  logic        mem_we;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata;
  logic [7:0]  sp;
  logic        res_valid;
  logic [15:0] res_pc;
  logic [7:0]  res_ps;
  logic [7:0]  res_data;

  always #4 clk = ~clk;

  stk_seq u_stk_seq (
    .clk(clk), .rst_n(rst_n), .page_sel(page_sel),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_pc(cmd_pc), .cmd_ps(cmd_ps), .cmd_data(cmd_data),
    .cmd_irq_en(cmd_irq_en), .cmd_src(cmd_src),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .sp(sp), .res_valid(res_valid), .res_pc(res_pc), .res_ps(res_ps),
    .res_data(res_data)
  );

  // bench memory: stack pages 0 and 1, plus the top page for vectors
  logic [7:0] bmem [0:767];
  logic [7:0] mmem [0:767];

  function automatic int midx(input logic [15:0] a);
    if (a[15:8] == 8'hFF) return 512 + int'(a[7:0]);
    return int'(a[8:0]);
  endfunction

  assign mem_rdata = bmem[midx(mem_addr)];

  always @(posedge clk)
    if (mem_valid && mem_ready && mem_we) bmem[midx(mem_addr)] <= mem_wdata;

  // reference model state
  logic [15:0] qa [$];
  logic        qw [$];
  logic [7:0]  qd [$];
  logic [7:0]  sp_m;
  int          checks = 0;
  int          errors = 0;
  string       cur_req = "R1";
  bit          mon_on = 0, stall_mode = 0, last_pop = 0, finished = 0;
  bit          exp_pending = 0, chk_pc = 0, chk_ps = 0, chk_data = 0;
  logic [15:0] exp_pc;
  logic [7:0]  exp_ps, exp_data, exp_sp;
  logic [7:0]  lfsr = 8'h5B;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic ex(input logic [15:0] a, input logic w, input logic [7:0] d);
    qa.push_back(a); qw.push_back(w); qd.push_back(d);
    if (w) mmem[midx(a)] = d;
  endtask

  function automatic logic [15:0] sa(input logic pg, input logic [7:0] s);
    return {7'd0, pg, s};
  endfunction

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (mon_on) begin
      if (stall_mode) begin
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        mem_ready = lfsr[0] | lfsr[3];
      end else mem_ready = 1'b1;
      if (last_pop) begin
        check(cur_req, "R11 res_valid after final transfer", res_valid, 1);
        check(cur_req, "R11 cmd_ready at completion", cmd_ready, 1);
      end
      last_pop = 0;
      if (res_valid) begin
        if (!exp_pending) check(cur_req, "unexpected result", 1, 0);
        else begin
          if (chk_pc)   check(cur_req, "res_pc", res_pc, exp_pc);
          if (chk_ps)   check(cur_req, "res_ps", res_ps, exp_ps);
          if (chk_data) check(cur_req, "res_data", res_data, exp_data);
          check(cur_req, "sp at completion", sp, exp_sp);
          exp_pending = 0;
        end
      end
      if (mem_valid) begin
        if (qa.size() == 0) check(cur_req, "unexpected memory cycle", mem_addr, 32'hDEAD);
        else begin
          check(cur_req, "mem_addr", mem_addr, qa[0]);
          check(cur_req, "mem_we", mem_we, qw[0]);
          if (qw[0]) check(cur_req, "mem_wdata", mem_wdata, qd[0]);
          if (mem_ready) begin
            void'(qa.pop_front()); void'(qw.pop_front()); void'(qd.pop_front());
            if (qa.size() == 0) last_pop = 1;
          end
        end
      end
    end
  end

  task automatic run(input logic [2:0] op, input logic [15:0] pc, input logic [7:0] ps,
                     input logic [7:0] d, input logic en, input logic [1:0] src,
                     input logic pg, input string req);
    bit taken;
    logic [15:0] a, v, pcs;
    logic [7:0] lo, hi, pst;
    int n;
    while (!cmd_ready) @(negedge clk);
    cur_req = req;
    cmd_op = op; cmd_pc = pc; cmd_ps = ps; cmd_data = d;
    cmd_irq_en = en; cmd_src = src; page_sel = pg; cmd_valid = 1'b1;
    taken = (op != 3'd0) && !((op == 3'd3) && (!en || ps[2]));
    chk_pc = 0; chk_ps = 0; chk_data = 0;
    if (taken) begin
      case (op)
        3'd1: begin
          pcs = pc - 16'd1;
          ex(sa(pg, sp_m), 1, pcs[15:8]); sp_m--;
          ex(sa(pg, sp_m), 1, pcs[7:0]);  sp_m--;
        end
        3'd2: begin
          sp_m++; a = sa(pg, sp_m); lo = mmem[midx(a)]; ex(a, 0, 0);
          sp_m++; a = sa(pg, sp_m); hi = mmem[midx(a)]; ex(a, 0, 0);
          exp_pc = {hi, lo} + 16'd1; chk_pc = 1;
        end
        3'd3, 3'd5: begin
          pst = (op == 3'd5) ? (ps | 8'h10) : (ps & 8'hEF);
          ex(sa(pg, sp_m), 1, pc[15:8]); sp_m--;
          ex(sa(pg, sp_m), 1, pc[7:0]);  sp_m--;
          ex(sa(pg, sp_m), 1, pst);      sp_m--;
          v = (op == 3'd5) ? 16'hFFDC : 16'hFFFC - {13'd0, src, 1'b0};
          lo = mmem[midx(v)]; ex(v, 0, 0);
          hi = mmem[midx(v + 16'd1)]; ex(v + 16'd1, 0, 0);
          exp_pc = {hi, lo}; exp_ps = (ps | 8'h04) & 8'hEF; chk_pc = 1; chk_ps = 1;
        end
        3'd4: begin
          sp_m++; a = sa(pg, sp_m); pst = mmem[midx(a)]; ex(a, 0, 0);
          sp_m++; a = sa(pg, sp_m); lo = mmem[midx(a)];  ex(a, 0, 0);
          sp_m++; a = sa(pg, sp_m); hi = mmem[midx(a)];  ex(a, 0, 0);
          exp_pc = {hi, lo}; exp_ps = pst & 8'hEF; chk_pc = 1; chk_ps = 1;
        end
        3'd6: begin
          ex(sa(pg, sp_m), 1, d); sp_m--;
        end
        default: begin
          sp_m++; a = sa(pg, sp_m); exp_data = mmem[midx(a)]; ex(a, 0, 0);
          chk_data = 1;
        end
      endcase
      exp_sp = sp_m;
      exp_pending = 1;
    end
    @(negedge clk);
    cmd_valid = 1'b0;
    if (!taken) begin
      repeat (4) @(negedge clk);
      check(req, "sp after ignored command", sp, sp_m);
    end else begin
      n = 0;
      while (exp_pending && n < 300) begin @(negedge clk); n++; end
      if (exp_pending) begin
        check(req, "result never arrived", 0, 1);
        exp_pending = 0;
      end
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog R11 actual=hung expected=complete");
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 768; i++) begin
      bmem[i] = 8'(i * 7 + 3);
      mmem[i] = 8'(i * 7 + 3);
    end
    sp_m = 8'hFF;
    repeat (3) @(negedge clk);
    check("R1", "reset sp", sp, 8'hFF);
    check("R11", "reset cmd_ready", cmd_ready, 1);
    check("R10", "reset mem_valid", mem_valid, 0);
    check("R11", "reset res_valid", res_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    mon_on = 1;

    run(3'd1, 16'h1234, 8'h00, 8'h00, 0, 0, 0, "R2");
    run(3'd2, 16'h0000, 8'h00, 8'h00, 0, 0, 0, "R3");
    check("R3", "return lands at call site", res_pc, 16'h1234);
    run(3'd6, 16'h0000, 8'h00, 8'hA5, 0, 0, 0, "R8");
    run(3'd6, 16'h0000, 8'h00, 8'h3C, 0, 0, 0, "R8");
    run(3'd7, 16'h0000, 8'h00, 8'h00, 0, 0, 0, "R8");
    run(3'd7, 16'h0000, 8'h00, 8'h00, 0, 0, 0, "R8");
    check("R8", "second pop returns first push", res_data, 8'hA5);
    run(3'd3, 16'h4000, 8'h81, 8'h00, 1, 1, 0, "R4");
    run(3'd4, 16'h0000, 8'h00, 8'h00, 0, 0, 0, "R7");
    check("R7", "rti restores interrupted pc", res_pc, 16'h4000);
    check("R7", "rti restores status", res_ps, 8'h81);
    run(3'd3, 16'h5000, 8'h00, 8'h00, 0, 2, 0, "R6");
    run(3'd3, 16'h5000, 8'h04, 8'h00, 1, 2, 0, "R6");
    run(3'd5, 16'h6002, 8'h04, 8'h00, 0, 0, 0, "R5");
    run(3'd4, 16'h0000, 8'h00, 8'h00, 0, 0, 0, "R7");
    check("R5", "break bit cleared on restore", res_ps, 8'h04);
    run(3'd3, 16'h7777, 8'h40, 8'h00, 1, 3, 0, "R4");
    run(3'd4, 16'h0000, 8'h00, 8'h00, 0, 0, 0, "R7");
    run(3'd1, 16'hABCD, 8'h00, 8'h00, 0, 0, 1, "R1");
    run(3'd2, 16'h0000, 8'h00, 8'h00, 0, 0, 1, "R1");
    check("R1", "page 1 call/return", res_pc, 16'hABCD);
    run(3'd7, 16'h0000, 8'h00, 8'h00, 0, 0, 0, "R9");
    check("R9", "pop wraps pointer to 00", sp, 8'h00);
    run(3'd1, 16'h0102, 8'h00, 8'h00, 0, 0, 0, "R9");
    run(3'd2, 16'h0000, 8'h00, 8'h00, 0, 0, 0, "R9");
    check("R9", "wrapped call/return", res_pc, 16'h0102);
    run(3'd6, 16'h0000, 8'h00, 8'h99, 0, 0, 0, "R9");
    check("R9", "push wraps pointer to FF", sp, 8'hFF);
    run(3'd0, 16'h0000, 8'h00, 8'h00, 0, 0, 0, "R6");

    stall_mode = 1;
    for (int k = 0; k < 6; k++) begin
      run(3'd1, 16'(16'h2000 + k * 16'h0111), 8'h00, 8'h00, 0, 0, k[0], "R10");
      run(3'd3, 16'(16'h3000 + k * 16'h0123), 8'(k * 8'h21) & 8'hFB, 8'h00, 1, 2'(k), k[0], "R10");
      run(3'd6, 16'h0000, 8'h00, 8'(k + 8'h50), 0, 0, k[0], "R10");
      run(3'd7, 16'h0000, 8'h00, 8'h00, 0, 0, k[0], "R10");
      run(3'd4, 16'h0000, 8'h00, 8'h00, 0, 0, k[0], "R10");
      run(3'd2, 16'h0000, 8'h00, 8'h00, 0, 0, k[0], "R10");
    end
    run(3'd5, 16'h0F0F, 8'hFF, 8'h00, 0, 1, 0, "R5");
    run(3'd4, 16'h0000, 8'h00, 8'h00, 0, 0, 0, "R7");
    stall_mode = 0;
    repeat (3) @(negedge clk);
    check("R10", "no cycles left over", qa.size(), 0);
    finished = 1;
    summary();
    $finish;
  end
endmodule